// File: doc/BRIEF.md
# Exception Entry and Trace Controller

This block sits beside a processor's completion stage and turns completion events into entries to two exceptions: the system call and the trace (single-step or branch-trace) exception. For each completed instruction it receives a strobe, the effective address of the instruction that follows, and flags saying whether the instruction was a branch, a system call, a return-from-interrupt, or whether it raised some other exception. The block owns the 32-bit machine state register. When an exception is taken, it saves the return address and a filtered copy of the state into two save registers, rewrites the state register, and issues a one-cycle fetch redirect.

A return-from-interrupt redirects fetch to the saved return address and restores part of the state register from the second save register. Software can load the state register through a write port. Because taking an exception is context-synchronizing, a completion presented while the redirect is being issued is dropped.

Bit numbering in this text is big-endian: state bit 0 is the most significant bit of the 32-bit word. The state bits used are the following, with the mask each one has in the word: power save 13 (0x0004_0000), interrupt little-endian 15 (0x0001_0000), external enable 16 (0x8000), user mode 17 (0x4000), float enable 18 (0x2000), machine-check enable 19 (0x1000), single-step 21 (0x0400), branch-trace 22 (0x0200), vector prefix 25 (0x0040), instruction translate 26 (0x0020), data translate 27 (0x0010), recoverable 30 (0x0002) and little-endian 31 (0x0001).

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the state register equals the RESET_MSR parameter, both save registers are zero and redirect_valid is 0.
- R2: A system call completion that did not fault is taken, and in the following cycle redirect_valid is 1 for one cycle with redirect_addr equal to the base OR 0x0000_0C00. The base is 0x0000_0000 when the vector prefix bit (mask 0x0040) is 0 and HI_BASE (default 0xFFF0_0000) when it is 1.
- R3: A trace exception is taken, with redirect_addr equal to the base OR 0x0000_0D00, when a completion that is not a return-from-interrupt finds the single-step bit (mask 0x0400) set, or finds the branch-trace bit (mask 0x0200) set and the completion is a branch. Any other plain completion changes nothing.
- R4: On either exception entry, save register 0 receives cmp_next_ea.
- R5: On either exception entry, save register 1 receives the old state with bits 1–4 and 10–15 cleared and every other bit copied. The copy mask is 0x87C0_FFFF.
- R6: On either exception entry, the state register clears the power save, external enable, user mode, float enable, single-step, branch-trace, both translate and recoverable bits (mask 0x0004_E632). Little-endian takes the old interrupt little-endian value, and every other bit keeps its value.
- R7: A completion flagged as faulted never takes a trace or system call exception and leaves both save registers and the state register unchanged.
- R8: When a system call completes with the trace condition also true, only the system call vector is taken.
- R9: A return-from-interrupt that did not fault redirects fetch to save register 0. It loads state bits 0 and 16–31 (mask 0x8000_FFFF) from save register 1, keeps the other bits, and is never itself traced.
- R10: A completion presented in the cycle when redirect_valid is 1 is ignored. redirect_valid never stays high for two cycles in a row.
- R11: msr_wr_en loads msr_wr_data into the state register only when no exception or return is taken in the same cycle. When one is taken, that event's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | An instruction completed this cycle |
| cmp_next_ea | input | 32 | Effective address of the instruction after the completing one |
| cmp_is_branch | input | 1 | Completing instruction is a branch |
| cmp_is_sc | input | 1 | Completing instruction is a system call |
| cmp_is_rfi | input | 1 | Completing instruction is a return-from-interrupt |
| cmp_faulted | input | 1 | Completing instruction raised another exception |
| msr_wr_en | input | 1 | Software write of the state register |
| msr_wr_data | input | 32 | Value for the software write |
| msr_q | output | 32 | Current state register |
| srr0_q | output | 32 | Save register 0 (return address) |
| srr1_q | output | 32 | Save register 1 (saved state) |
| redirect_valid | output | 1 | Fetch redirect strobe, one cycle |
| redirect_addr | output | 32 | Fetch redirect target |

## Verification
The bench builds the block with RESET_MSR = 0x0001_0040. With the vector prefix bit set from reset, the high base 0xFFF0_0000 is exercised before any software write. With the interrupt little-endian bit set, the little-endian copy on entry produces a visible 1. A later state write clears the prefix bit, so both base choices are reached, and HI_BASE keeps its default.

// File: rtl/exc_pkg.sv
// Package: state-bit positions (big-endian numbering, bit 0 = MSB), derived masks
// and the event encoding shared by the exception entry controller.
// Assumes a 32-bit state register.
package exc_pkg;

    localparam int MSR_W = 32;

    // Big-endian bit positions of the state fields used here.
    localparam int MB_PWR    = 13;
    localparam int MB_ILE    = 15;
    localparam int MB_EXTEN  = 16;
    localparam int MB_USER   = 17;
    localparam int MB_FPU    = 18;
    localparam int MB_STEP   = 21;
    localparam int MB_BRTR   = 22;
    localparam int MB_PREFIX = 25;
    localparam int MB_ITRANS = 26;
    localparam int MB_DTRANS = 27;
    localparam int MB_RECOV  = 30;
    localparam int MB_LEMODE = 31;

    // Little-endian index of a big-endian bit position.
    function automatic int le_idx(input int be);
        return MSR_W - 1 - be;
    endfunction

    // Single-bit mask for a big-endian position.
    function automatic logic [MSR_W-1:0] bit_mask(input int be);
        return {{(MSR_W-1){1'b0}}, 1'b1} << le_idx(be);
    endfunction

    // Mask covering big-endian positions lo..hi inclusive.
    function automatic logic [MSR_W-1:0] span_mask(input int lo, input int hi);
        logic [MSR_W-1:0] m;
        m = '0;
        for (int i = lo; i <= hi; i++) m = m | bit_mask(i);
        return m;
    endfunction

    localparam logic [MSR_W-1:0] SAVE_KEEP =
        span_mask(0, 0) | span_mask(5, 9) | span_mask(16, 31);

    localparam logic [MSR_W-1:0] RESTORE_MASK = span_mask(0, 0) | span_mask(16, 31);

    localparam logic [MSR_W-1:0] ENTRY_CLR =
        bit_mask(MB_PWR) | bit_mask(MB_EXTEN) | bit_mask(MB_USER) | bit_mask(MB_FPU) |
        bit_mask(MB_STEP) | bit_mask(MB_BRTR) | bit_mask(MB_ITRANS) |
        bit_mask(MB_DTRANS) | bit_mask(MB_RECOV) | bit_mask(MB_LEMODE);

    localparam int IDX_ILE    = MSR_W - 1 - MB_ILE;
    localparam int IDX_LE     = MSR_W - 1 - MB_LEMODE;
    localparam int IDX_STEP   = MSR_W - 1 - MB_STEP;
    localparam int IDX_BRTR   = MSR_W - 1 - MB_BRTR;
    localparam int IDX_PREFIX = MSR_W - 1 - MB_PREFIX;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_SC    = 2'd1,
        EV_TRACE = 2'd2,
        EV_RET   = 2'd3
    } exc_ev_t;

endpackage

// File: rtl/trap_decide.sv
// Module: trap_decide
// Combinational event selection for one completion. Priority: a faulted
// instruction takes nothing here; a system call beats a return, which beats trace.
// Assumes the caller blocks completions while a redirect is being issued.
module trap_decide
    import exc_pkg::*;
(
    input  logic    cmp_valid,
    input  logic    blocked,
    input  logic    is_branch,
    input  logic    is_sc,
    input  logic    is_rfi,
    input  logic    faulted,
    input  logic    step_en,
    input  logic    brtr_en,
    output exc_ev_t ev
);
    logic live;
    logic trace_hit;

    // Qualify the completion and evaluate the trace condition.
    always_comb begin
        live      = cmp_valid && !blocked && !faulted;
        trace_hit = step_en || (brtr_en && is_branch);
    end

    // Pick one event by priority.
    always_comb begin
        if (!live)          ev = EV_NONE;
        else if (is_sc)     ev = EV_SC;
        else if (is_rfi)    ev = EV_RET;
        else if (trace_hit) ev = EV_TRACE;
        else                ev = EV_NONE;
    end
endmodule

// File: rtl/msr_reg.sv
// Module: msr_reg
// Holds the state register; applies exception-entry rewrite, return restore,
// or a software write, in that priority. Synchronous active-low reset.
module msr_reg
    import exc_pkg::*;
#(
    parameter logic [31:0] RESET_MSR = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  exc_ev_t          ev,
    input  logic             wr_en,
    input  logic [MSR_W-1:0] wr_data,
    input  logic [MSR_W-1:0] srr1,
    output logic [MSR_W-1:0] msr
);
    logic [MSR_W-1:0] entry_val;

    // Entry value: clear the listed fields, little-endian takes interrupt little-endian.
    always_comb begin
        entry_val         = msr & ~ENTRY_CLR;
        entry_val[IDX_LE] = msr[IDX_ILE];
    end

    // State register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr <= RESET_MSR;
        end else begin
            unique case (ev)
                EV_SC, EV_TRACE: msr <= entry_val;
                EV_RET:          msr <= (msr & ~RESTORE_MASK) | (srr1 & RESTORE_MASK);
                default:         if (wr_en) msr <= wr_data;
            endcase
        end
    end
endmodule

// File: rtl/save_regs.sv
// Module: save_regs
// Save registers written on exception entry: return address and filtered state.
// Assumes ev is EV_SC or EV_TRACE only for a taken exception.
module save_regs
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  exc_ev_t          ev,
    input  logic [31:0]      next_ea,
    input  logic [MSR_W-1:0] msr,
    output logic [31:0]      srr0,
    output logic [MSR_W-1:0] srr1
);
    // Capture return address and masked state on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srr0 <= '0;
            srr1 <= '0;
        end else if (ev == EV_SC || ev == EV_TRACE) begin
            srr0 <= next_ea;
            srr1 <= msr & SAVE_KEEP;
        end
    end
endmodule

// File: rtl/redirect_gen.sv
// Module: redirect_gen
// Registers a one-cycle fetch redirect: exception vector on entry, saved
// return address on return. Base chosen by the vector prefix bit.
module redirect_gen
    import exc_pkg::*;
#(
    parameter logic [31:0] HI_BASE = 32'hFFF0_0000,
    parameter logic [31:0] SC_OFF  = 32'h0000_0C00,
    parameter logic [31:0] TR_OFF  = 32'h0000_0D00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  exc_ev_t     ev,
    input  logic        prefix,
    input  logic [31:0] ret_addr,
    output logic        valid,
    output logic [31:0] addr
);
    logic [31:0] base;

    // Select vector base from the prefix bit.
    always_comb base = prefix ? HI_BASE : 32'h0;

    // Issue the redirect one cycle after the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
        end else begin
            valid <= (ev != EV_NONE);
            unique case (ev)
                EV_SC:    addr <= base | SC_OFF;
                EV_TRACE: addr <= base | TR_OFF;
                EV_RET:   addr <= ret_addr;
                default:  addr <= addr;
            endcase
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: exc_entry_ctrl (top)
// Exception entry and trace controller: decides system-call, trace and return
// events per completion, keeps the state and save registers, and issues the
// fetch redirect. Completions are ignored while a redirect is out (context sync).
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter logic [31:0] RESET_MSR = 32'h0,
    parameter logic [31:0] HI_BASE   = 32'hFFF0_0000,
    parameter logic [31:0] SC_OFF    = 32'h0000_0C00,
    parameter logic [31:0] TR_OFF    = 32'h0000_0D00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmp_valid,
    input  logic [31:0] cmp_next_ea,
    input  logic        cmp_is_branch,
    input  logic        cmp_is_sc,
    input  logic        cmp_is_rfi,
    input  logic        cmp_faulted,
    input  logic        msr_wr_en,
    input  logic [31:0] msr_wr_data,
    output logic [31:0] msr_q,
    output logic [31:0] srr0_q,
    output logic [31:0] srr1_q,
    output logic        redirect_valid,
    output logic [31:0] redirect_addr
);
    exc_ev_t ev;

    trap_decide u_decide (
        .cmp_valid (cmp_valid),
        .blocked   (redirect_valid),
        .is_branch (cmp_is_branch),
        .is_sc     (cmp_is_sc),
        .is_rfi    (cmp_is_rfi),
        .faulted   (cmp_faulted),
        .step_en   (msr_q[IDX_STEP]),
        .brtr_en   (msr_q[IDX_BRTR]),
        .ev        (ev)
    );

    msr_reg #(.RESET_MSR(RESET_MSR)) u_msr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .wr_en   (msr_wr_en),
        .wr_data (msr_wr_data),
        .srr1    (srr1_q),
        .msr     (msr_q)
    );

    save_regs u_save (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .next_ea (cmp_next_ea),
        .msr     (msr_q),
        .srr0    (srr0_q),
        .srr1    (srr1_q)
    );

    redirect_gen #(.HI_BASE(HI_BASE), .SC_OFF(SC_OFF), .TR_OFF(TR_OFF)) u_redir (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .prefix   (msr_q[IDX_PREFIX]),
        .ret_addr (srr0_q),
        .valid    (redirect_valid),
        .addr     (redirect_addr)
    );

    // Redirect is a single-cycle pulse.
    assert_redirect_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    // A completion during the redirect cycle selects no event.
    assert_blocked_completion_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && cmp_valid) |-> ev == EV_NONE);

    // Faulted instructions never trigger trace.
    assert_no_trace_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_faulted) |-> ev != EV_TRACE);

    // System call outranks trace on the same completion.
    assert_sc_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !redirect_valid && !cmp_faulted && cmp_is_sc) |-> ev == EV_SC);

    // Return address captured on entry.
    assert_srr0_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SC || ev == EV_TRACE) |=> srr0_q == $past(cmp_next_ea));

    // Cleared fields of save register 1 are zero after entry.
    assert_srr1_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SC || ev == EV_TRACE) |=> (srr1_q & ~SAVE_KEEP) == 32'h0);

    // Entry clears the listed state fields and copies interrupt little-endian.
    assert_entry_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SC || ev == EV_TRACE) |=>
            ((msr_q & ENTRY_CLR & ~bit_mask(MB_LEMODE)) == 32'h0) &&
            (msr_q[IDX_LE] == $past(msr_q[IDX_ILE])));

    // Every event produces a redirect in the next cycle.
    assert_event_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != EV_NONE) |=> redirect_valid);
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
    localparam logic [31:0] RST_MSR = 32'h0001_0040;
    localparam logic [31:0] KEEP1   = 32'h87C0_FFFF;
    localparam logic [31:0] CLR     = 32'h0004_E633;
    localparam logic [31:0] RESTORE = 32'h8000_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_valid = 0, cmp_is_branch = 0, cmp_is_sc = 0, cmp_is_rfi = 0, cmp_faulted = 0;
    logic [31:0] cmp_next_ea = '0;
    logic msr_wr_en = 0;
    logic [31:0] msr_wr_data = '0;
    logic [31:0] msr_q, srr0_q, srr1_q, redirect_addr;
    logic redirect_valid;

    always #10 clk = ~clk;  // 50 MHz

    exc_entry_ctrl #(.RESET_MSR(RST_MSR)) dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_next_ea(cmp_next_ea),
        .cmp_is_branch(cmp_is_branch), .cmp_is_sc(cmp_is_sc), .cmp_is_rfi(cmp_is_rfi),
        .cmp_faulted(cmp_faulted), .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
        .msr_q(msr_q), .srr0_q(srr0_q), .srr1_q(srr1_q),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
    );

    typedef struct {
        logic [31:0] addr;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int tests = 0, fails = 0;
    logic done = 0;
    logic [31:0] m_msr, m_srr0, m_srr1;
    logic m_busy;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop expected redirect on every observed redirect.
    always @(negedge clk) begin
        if (rst_n && redirect_valid) begin
            if (sb.size() == 0) begin
                tests++; fails++;
                $display("FAIL R10 unexpected redirect: actual %h expected none", redirect_addr);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "redirect_addr", redirect_addr, e.addr);
            end
        end
    end

    // Driver: apply one cycle of stimulus, update the model, push expectations, check state ports.
    task automatic step(input logic c, input logic [31:0] ea, input logic br, input logic sc,
                        input logic rfi, input logic flt, input logic we, input logic [31:0] wd,
                        input string tag);
        logic live, trc;
        logic [31:0] base, nm;
        cmp_valid = c; cmp_next_ea = ea; cmp_is_branch = br; cmp_is_sc = sc;
        cmp_is_rfi = rfi; cmp_faulted = flt; msr_wr_en = we; msr_wr_data = wd;
        live = c && !m_busy && !flt;
        trc  = m_msr[10] || (m_msr[9] && br);
        base = m_msr[6] ? 32'hFFF0_0000 : 32'h0;
        m_busy = 1'b0;
        if (live && (sc || (!rfi && trc))) begin
            sb.push_back('{addr: base | (sc ? 32'h0C00 : 32'h0D00), tag: tag});
            m_srr0 = ea;
            m_srr1 = m_msr & KEEP1;
            nm = m_msr & ~CLR;
            nm[0] = m_msr[16];
            m_msr = nm;
            m_busy = 1'b1;
        end else if (live && rfi) begin
            sb.push_back('{addr: m_srr0, tag: tag});
            m_msr = (m_msr & ~RESTORE) | (m_srr1 & RESTORE);
            m_busy = 1'b1;
        end else if (we) begin
            m_msr = wd;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "msr", msr_q, m_msr);
        chk(tag, "srr0", srr0_q, m_srr0);
        chk(tag, "srr1", srr1_q, m_srr1);
    endtask

    task automatic idle();
        step(0, 32'h0, 0, 0, 0, 0, 0, 32'h0, "idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_msr = RST_MSR; m_srr0 = '0; m_srr1 = '0; m_busy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "msr", msr_q, RST_MSR);
        chk("R1", "srr0", srr0_q, 32'h0);
        chk("R1", "srr1", srr1_q, 32'h0);
        chk("R1", "redirect_valid", {31'h0, redirect_valid}, 32'h0);
        // R3: plain completion with no trace enable does nothing
        step(1, 32'h0000_1000, 1, 0, 0, 0, 0, 32'h0, "R3");
        // R11: software write sets single-step, power save, external enable, bit 0
        step(0, 32'h0, 0, 0, 0, 0, 1, 32'h8005_9440, "R11");
        // R3 R4 R5 R6: single-step trace at high base
        step(1, 32'h0000_1004, 0, 0, 0, 0, 0, 32'h0, "R3");
        // R10: completion during redirect cycle ignored
        step(1, 32'h0000_2000, 0, 1, 0, 0, 0, 32'h0, "R10");
        // R9: return restores state and goes back to saved address
        step(1, 32'h0000_3000, 1, 0, 1, 0, 0, 32'h0, "R9");
        idle();
        // R9: return while single-step is on is not traced
        step(1, 32'h0000_3100, 1, 0, 1, 0, 0, 32'h0, "R9");
        idle();
        // R7: faulted completion with single-step on takes nothing
        step(1, 32'h0000_1008, 1, 0, 0, 1, 0, 32'h0, "R7");
        // R7: faulted system call takes nothing
        step(1, 32'h0000_100C, 0, 1, 0, 1, 0, 32'h0, "R7");
        // R8 R2: system call with trace condition true; system call vector only
        step(1, 32'h0000_1010, 1, 1, 0, 0, 0, 32'h0, "R8");
        idle();
        step(1, 32'h0000_3200, 1, 0, 1, 0, 0, 32'h0, "R9");
        idle();
        // R11: write clears prefix, enables branch trace only
        step(0, 32'h0, 0, 0, 0, 0, 1, 32'h0001_0200, "R11");
        // R3: non-branch completion with branch trace only does nothing
        step(1, 32'h0000_4000, 0, 0, 0, 0, 0, 32'h0, "R3");
        // R3: branch completion traced at low base
        step(1, 32'h0000_4004, 1, 0, 0, 0, 0, 32'h0, "R3");
        idle();
        // R2 R11: system call at low base beats concurrent state write
        step(1, 32'h0000_5000, 0, 1, 0, 0, 1, 32'hFFFF_FFFF, "R2");
        idle();
        step(0, 32'h0, 0, 0, 0, 0, 0, 32'h0, "R2");
        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2 redirects missing: actual %0d expected 0", sb.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule